// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Colour-Space Converter

This block converts one pixel between gamma-corrected RGB and the luma/chroma form (Y', Cr, Cb) with no multiplier. A load strobe captures three 8-bit components and a direction select. The block then walks the component bits from least to most significant over eight clocks. On each clock it takes one bit from each component and forms a 3-bit address. That address selects, for each of the three outputs, a precomputed sum of matrix coefficients from a small read-only table. The table value is shifted left by the bit position and added into a per-output accumulator.

Two banks of three 8-entry tables hold the coefficient sums, one bank per direction. The constant column of the matrix is not stored in the tables. It is preloaded into each accumulator together with one half LSB of the output, so that dropping the fraction at the end rounds to nearest. A one-cycle done strobe marks new results on the three output ports. These outputs hold their value until the next result.

Control is a three-state machine. IDLE waits for a load and moves to SHIFT when one is accepted. SHIFT spends eight clocks accumulating bit positions 0 to 7 and moves to FINAL after bit 7. FINAL captures the rounded and clamped results. From FINAL the machine moves to SHIFT if a load is accepted in that cycle, and to IDLE otherwise.

Top module: `pix_da_conv`

## Requirements
- R1: While reset is held and after it is released, all three outputs read 0 and done reads 0 until the first result.
- R2: A load is accepted on any clock edge where the machine is not in SHIFT. The edge captures the three components and the direction select.
- R3: With direction 0 (forward), inputs are (R, G, B) and outputs are (Y, Cr, Cb). The coefficients are in units of 1/32: Y=(8R+16G+3B+512), Cr=(14R−12G−2B+4096) and Cb=(−5R−9G+14B+4096).
- R4: With direction 1 (inverse), inputs are (Y, Cr, Cb) and outputs are (R, G, B). The coefficients are in units of 1/32: R=(37Y+51Cr−7133), G=(37Y−26Cr−13Cb+4340) and B=(37Y+65Cb−8858).
- R5: Each output is floor((sum+16)/32), so results round half up.
- R6: A result below 0 reads as 0, and a result above 255 reads as 255.
- R7: done is high for exactly one cycle, in the cycle that follows the ninth clock edge after the accepting edge. The outputs change only at that edge.
- R8: A load presented while in SHIFT is ignored. The running result is unchanged and no extra done strobe follows.
- R9: The direction select is used only at the accepting edge. Changes to it during SHIFT have no effect on the result.
- R10: Between done strobes the outputs hold their last values.
- R11: A load accepted in the FINAL cycle starts a new pixel at once. Results from that load appear 9 cycles after the previous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start strobe for a new pixel |
| dir_sel | input | 1 | 0 = RGB to Y'CrCb, 1 = Y'CrCb to RGB |
| comp0_in | input | 8 | First input component (R or Y) |
| comp1_in | input | 8 | Second input component (G or Cr) |
| comp2_in | input | 8 | Third input component (B or Cb) |
| comp0_out | output | 8 | First output component (Y or R) |
| comp1_out | output | 8 | Second output component (Cr or G) |
| comp2_out | output | 8 | Third output component (Cb or B) |
| done | output | 1 | One-cycle strobe: new results valid |

## Verification
Any fault in the bit counter or the state machine shows at the ports within one pixel. The done strobe then arrives on the wrong cycle, or not at all, and the outputs change away from the strobe. A wrong table entry, preload, or shift amount shows as a wrong output value only for the input bit patterns that reach it. For that reason the sweep runs a grid over all three components in both directions, which drives every address at every bit position. A latched select or data register that leaks a mid-run change shows in the very next result.

// File: rtl/pix_da_pkg.sv
package pix_da_pkg;
    localparam int COMP_W = 8;
    localparam int FRAC_W = 5;
    localparam int TBL_W  = 13;
    localparam int ACC_W  = 18;
    localparam int N_CH   = 3;
    localparam int CNT_W  = $clog2(COMP_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FINAL
    } da_state_e;

    // Matrix coefficients in units of 2^-FRAC_W; column 3 is the offset.
    localparam int FWD_K [0:2][0:3] = '{
        '{  8,  16,   3,   512},
        '{ 14, -12,  -2,  4096},
        '{ -5,  -9,  14,  4096}
    };
    localparam int INV_K [0:2][0:3] = '{
        '{ 37,  51,   0, -7133},
        '{ 37, -26, -13,  4340},
        '{ 37,   0,  65, -8858}
    };

    function automatic int coef(input logic dir, input int row, input int col);
        return dir ? INV_K[row][col] : FWD_K[row][col];
    endfunction

    // Sum of the coefficients picked by the three address bits.
    function automatic int table_entry(input logic dir, input int row, input int addr);
        int s;
        s = 0;
        for (int c = 0; c < N_CH; c++) begin
            if (((addr >> c) & 1) == 1) s += coef(dir, row, c);
        end
        return s;
    endfunction

    // Offset plus one half of an output LSB.
    function automatic int preload_val(input logic dir, input int row);
        return coef(dir, row, 3) + (1 << (FRAC_W - 1));
    endfunction
endpackage

// File: rtl/pix_da_rom_bank.sv
module pix_da_rom_bank
    import pix_da_pkg::*;
(
    input  logic                    dir,
    input  logic [N_CH-1:0]         addr,
    output logic signed [TBL_W-1:0] part [0:N_CH-1]
);
    localparam int DEPTH = 1 << N_CH;

    logic signed [TBL_W-1:0] rom_fwd [0:N_CH-1][0:DEPTH-1];
    logic signed [TBL_W-1:0] rom_inv [0:N_CH-1][0:DEPTH-1];

    for (genvar r = 0; r < N_CH; r++) begin : g_row
        for (genvar a = 0; a < DEPTH; a++) begin : g_ent
            localparam logic signed [TBL_W-1:0] E_FWD = TBL_W'(table_entry(1'b0, r, a));
            localparam logic signed [TBL_W-1:0] E_INV = TBL_W'(table_entry(1'b1, r, a));
            assign rom_fwd[r][a] = E_FWD;
            assign rom_inv[r][a] = E_INV;
        end
        assign part[r] = dir ? rom_inv[r][addr] : rom_fwd[r][addr];
    end
endmodule

// File: rtl/pix_da_serializer.sv
module pix_da_serializer
    import pix_da_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [COMP_W-1:0] in0,
    input  logic [COMP_W-1:0] in1,
    input  logic [COMP_W-1:0] in2,
    output logic [N_CH-1:0]   addr
);
    logic [COMP_W-1:0] sh_q [0:N_CH-1];
    logic [COMP_W-1:0] src  [0:N_CH-1];

    assign src[0] = in0;
    assign src[1] = in1;
    assign src[2] = in2;

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q[c] <= '0;
            end else if (load_en) begin
                sh_q[c] <= src[c];
            end else if (shift_en) begin
                sh_q[c] <= {1'b0, sh_q[c][COMP_W-1:1]};
            end
        end
        assign addr[c] = sh_q[c][0];
    end
endmodule

// File: rtl/pix_da_accum.sv
module pix_da_accum
    import pix_da_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic                    load_dir,
    input  logic                    shift_en,
    input  logic                    capture_en,
    input  logic [CNT_W-1:0]        shamt,
    input  logic signed [TBL_W-1:0] part,
    output logic [COMP_W-1:0]       result
);
    localparam int WH_W = ACC_W - FRAC_W;
    localparam logic signed [ACC_W-1:0] PRE_FWD = ACC_W'(preload_val(1'b0, ROW));
    localparam logic signed [ACC_W-1:0] PRE_INV = ACC_W'(preload_val(1'b1, ROW));
    localparam logic signed [WH_W-1:0]  MAX_V   = WH_W'((1 << COMP_W) - 1);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] term;
    logic signed [WH_W-1:0]  whole;
    logic [COMP_W-1:0]       clamped;
    logic [COMP_W-1:0]       res_q;

    assign term  = ACC_W'(part) <<< shamt;
    assign whole = $signed(acc_q[ACC_W-1:FRAC_W]);

    always_comb begin
        if (whole < 0)          clamped = '0;
        else if (whole > MAX_V) clamped = '1;
        else                    clamped = whole[COMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= load_dir ? PRE_INV : PRE_FWD;
        end else if (shift_en) begin
            acc_q <= acc_q + term;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          res_q <= '0;
        else if (capture_en) res_q <= clamped;
    end

    assign result = res_q;
endmodule

// File: rtl/pix_da_ctrl.sv
module pix_da_ctrl
    import pix_da_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dir_sel,
    output logic             load_en,
    output logic             shift_en,
    output logic             capture_en,
    output logic [CNT_W-1:0] shamt,
    output logic             busy,
    output logic             dir_q,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(COMP_W - 1);

    da_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= capture_en;
            if (load_en) begin
                cnt_q <= '0;
                dir_q <= dir_sel;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        load_en    = 1'b0;
        shift_en   = 1'b0;
        capture_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    load_en = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                if (cnt_q == LAST_BIT) state_d = ST_FINAL;
            end
            ST_FINAL: begin
                capture_en = 1'b1;
                if (load) begin
                    load_en = 1'b1;
                    state_d = ST_SHIFT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign shamt = cnt_q;
    assign busy  = (state_q == ST_SHIFT);
    assign done  = done_q;
endmodule

// File: rtl/pix_da_conv.sv
module pix_da_conv
    import pix_da_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dir_sel,
    input  logic [COMP_W-1:0] comp0_in,
    input  logic [COMP_W-1:0] comp1_in,
    input  logic [COMP_W-1:0] comp2_in,
    output logic [COMP_W-1:0] comp0_out,
    output logic [COMP_W-1:0] comp1_out,
    output logic [COMP_W-1:0] comp2_out,
    output logic              done
);
    logic                    load_en, shift_en, capture_en, busy, dir_q;
    logic [CNT_W-1:0]        shamt;
    logic [N_CH-1:0]         addr;
    logic signed [TBL_W-1:0] part [0:N_CH-1];
    logic [COMP_W-1:0]       res  [0:N_CH-1];

    pix_da_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .dir_sel(dir_sel),
        .load_en(load_en), .shift_en(shift_en), .capture_en(capture_en),
        .shamt(shamt), .busy(busy), .dir_q(dir_q), .done(done)
    );

    pix_da_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
        .in0(comp0_in), .in1(comp1_in), .in2(comp2_in), .addr(addr)
    );

    pix_da_rom_bank u_rom (
        .dir(dir_q), .addr(addr), .part(part)
    );

    for (genvar r = 0; r < N_CH; r++) begin : g_acc
        pix_da_accum #(.ROW(r)) u_acc (
            .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dir(dir_sel),
            .shift_en(shift_en), .capture_en(capture_en), .shamt(shamt),
            .part(part[r]), .result(res[r])
        );
    end

    assign comp0_out = res[0];
    assign comp1_out = res[1];
    assign comp2_out = res[2];
endmodule

// File: rtl/pix_da_conv_chk.sv
module pix_da_conv_chk
    import pix_da_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              busy,
    input logic              dir_q,
    input logic              done,
    input logic [COMP_W-1:0] comp0_out
);
    localparam int LAT   = COMP_W + 1;
    localparam int LAT_W = $clog2(LAT + 1);

    logic [LAT_W-1:0] cnt_q;
    logic             exp_done_q;
    logic             accept;

    assign accept = load && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            exp_done_q <= 1'b0;
        end else begin
            exp_done_q <= (cnt_q == LAT_W'(LAT));
            if (accept)                                  cnt_q <= LAT_W'(1);
            else if (cnt_q != 0 && cnt_q < LAT_W'(LAT))  cnt_q <= cnt_q + 1'b1;
            else                                         cnt_q <= '0;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == exp_done_q);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(comp0_out) |-> done);

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir_q));
endmodule

bind pix_da_conv pix_da_conv_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy),
    .dir_q(dir_q), .done(done), .comp0_out(comp0_out)
);

// File: tb/pix_da_conv_tb.sv
`timescale 1ns/1ps
module pix_da_conv_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       dir_sel = 1'b0;
    logic [7:0] c0 = '0, c1 = '0, c2 = '0;
    logic [7:0] o0, o1, o2;
    logic       done;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    pix_da_conv u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .dir_sel(dir_sel),
        .comp0_in(c0), .comp1_in(c1), .comp2_in(c2),
        .comp0_out(o0), .comp1_out(o1), .comp2_out(o2), .done(done)
    );

    function automatic int model(input int dir, input int row, input int x0, input int x1, input int x2);
        int k0, k1, k2, k3, s, w;
        case ({dir[0], row[1:0]})
            3'b000: begin k0 = 8;   k1 = 16;  k2 = 3;   k3 = 512;   end
            3'b001: begin k0 = 14;  k1 = -12; k2 = -2;  k3 = 4096;  end
            3'b010: begin k0 = -5;  k1 = -9;  k2 = 14;  k3 = 4096;  end
            3'b100: begin k0 = 37;  k1 = 51;  k2 = 0;   k3 = -7133; end
            3'b101: begin k0 = 37;  k1 = -26; k2 = -13; k3 = 4340;  end
            default: begin k0 = 37; k1 = 0;   k2 = 65;  k3 = -8858; end
        endcase
        s = k0 * x0 + k1 * x1 + k2 * x2 + k3 + 16;
        w = s >>> 5;
        if (w < 0) w = 0;
        if (w > 255) w = 255;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_pix(input string req, input int dir, input int x0, input int x1, input int x2);
        int e0, e1, e2;
        e0 = model(dir, 0, x0, x1, x2);
        e1 = model(dir, 1, x0, x1, x2);
        e2 = model(dir, 2, x0, x1, x2);
        check(done == 1'b1, {req, " done"}, int'(done), 1);
        check(int'(o0) == e0 && int'(o1) == e1 && int'(o2) == e2, req,
              int'({o0, o1, o2}), (e0 << 16) | (e1 << 8) | e2);
    endtask

    task automatic drive(input int dir, input int x0, input int x1, input int x2);
        load = 1'b1; dir_sel = dir[0];
        c0 = x0[7:0]; c1 = x1[7:0]; c2 = x2[7:0];
    endtask

    // Load at edge E0, results visible after edge E9.
    task automatic run_pixel(input string req, input int dir, input int x0, input int x1, input int x2);
        @(negedge clk); drive(dir, x0, x1, x2);
        @(posedge clk);
        @(negedge clk); load = 1'b0;
        repeat (9) @(posedge clk);
        @(negedge clk);
        check_pix(req, dir, x0, x1, x2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(o0 == 0 && o1 == 0 && o2 == 0, "R1 outputs in reset", int'({o0, o1, o2}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && o0 == 0, "R1 after reset", int'(done), 0);

        // R3 R4 R5 R6 R2: grid sweep over both directions
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < 256; a += 17) begin
                for (int b = 0; b < 256; b += 17) begin
                    for (int c = 0; c < 256; c += 17) begin
                        run_pixel(d == 0 ? "R3 forward" : "R4 inverse", d, a, b, c);
                    end
                end
            end
        end
        // R5 R6: rounding and clamp corners
        run_pixel("R5 round corner", 0, 1, 1, 1);
        run_pixel("R6 clamp low", 1, 0, 0, 0);
        run_pixel("R6 clamp high", 1, 255, 255, 255);
        run_pixel("R3 white", 0, 255, 255, 255);

        // R8 R9 R10: load and select changes during SHIFT are ignored
        begin
            @(negedge clk); drive(0, 200, 40, 90);
            @(posedge clk);
            @(negedge clk); load = 1'b0;
            repeat (3) @(posedge clk);
            @(negedge clk); drive(1, 7, 250, 13);
            @(posedge clk);
            @(negedge clk); load = 1'b0; dir_sel = 1'b1;
            repeat (5) @(posedge clk);
            @(negedge clk);
            check_pix("R8 R9 ignored load", 0, 200, 40, 90);
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                check(done == 0, "R8 no extra done", int'(done), 0);
                check(o0 == 8'(model(0, 0, 200, 40, 90)), "R10 hold", int'(o0), model(0, 0, 200, 40, 90));
            end
            dir_sel = 1'b0;
        end

        // R11 R7: back-to-back via the FINAL cycle
        begin
            @(negedge clk); drive(0, 30, 180, 60);
            @(posedge clk);
            @(negedge clk); load = 1'b0;
            repeat (8) @(posedge clk);
            @(negedge clk); drive(1, 120, 90, 200);
            @(posedge clk);
            @(negedge clk); load = 1'b0;
            check_pix("R11 first", 0, 30, 180, 60);
            @(negedge clk);
            check(done == 0, "R7 single-cycle done", int'(done), 0);
            repeat (7) @(posedge clk);
            @(negedge clk);
            check(done == 0, "R7 not early", int'(done), 0);
            @(posedge clk);
            @(negedge clk);
            check_pix("R11 second", 1, 120, 90, 200);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule